// File: doc/BRIEF.md
# Interrupt Status and Mask Unit

This unit gathers single-cycle event pulses from a network controller's receive path, transmit path, remote DMA channel and start/stop control into an 8-bit interrupt status register. A 7-bit mask selects which status bits may raise the single interrupt request line. A host reads status, clears bits and writes the mask through a small register port. The port has a write strobe, a read strobe and a 3-bit address, and read data is returned combinationally in the same cycle.

Three 8-bit network tally counters live inside the unit because their overflow feeds the status register. They count alignment errors, CRC errors and missed packets. Each counter saturates at its maximum and clears when the host reads it. Bit 7 of the status register reports the stopped state. The host cannot write it, and it never raises the interrupt.

Top module: `irq_status_unit`

## Requirements
- R1: After reset the status register reads 0x80, the mask reads 0x00, all three counters read 0 and `irq` is low.
- R2: At the clock edge that samples the pulse, a pulse on `ev_rx_ok`, `ev_tx_ok`, `ev_ring_ovw` or `ev_rdma_done` sets status bit 0, 1, 4 or 6 respectively.
- R3: Status bit 2 (receive error) is set by a pulse on any of `ev_rx_crc`, `ev_rx_align`, `ev_rx_fifo_ovr` or `ev_rx_missed`.
- R4: Status bit 3 (transmit error) is set by a pulse on `ev_tx_excoll` or `ev_tx_underrun`.
- R5: A host write to address 0 clears each status bit 0 to 6 whose data bit is 1. Data bits that are 0 leave their status bits unchanged. An event that arrives in the same cycle as the clear wins, and its bit stays set.
- R6: Status bit 7 is set by `cmd_stop` or `ev_ring_ovw` and cleared by `cmd_start` or `ev_pkt_removed`. If a set and a clear arrive together, the set wins. Host writes never change bit 7.
- R7: Address 1 holds the mask. Data bits 6:0 are stored on a write, and bit 7 always reads 0.
- R8: `irq` is high exactly when some status bit among 0 to 6 is set together with its mask bit. It is registered-state driven, so it follows the status change one edge after an event. Status bit 7 never drives `irq`.
- R9: Addresses 2, 3 and 4 read the alignment-error, CRC-error and missed-packet counters. Each counter adds one per pulse on `ev_rx_align`, `ev_rx_crc` or `ev_rx_missed` respectively, and holds at 255 instead of wrapping.
- R10: A read of a counter address returns the current value and clears that counter at the same edge. If an increment arrives in the same cycle as the read, the counter holds 1 after the edge.
- R11: Status bit 5 is set at the edge where any counter's MSB changes from 0 to 1, that is, when the counter reaches 128.
- R12: Reads of addresses 5 to 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ev_rx_ok | input | 1 | Frame received without error |
| ev_tx_ok | input | 1 | Frame transmitted without error |
| ev_rx_crc | input | 1 | Received frame had a CRC error |
| ev_rx_align | input | 1 | Received frame had an alignment error |
| ev_rx_fifo_ovr | input | 1 | Receive FIFO overrun |
| ev_rx_missed | input | 1 | Frame missed for lack of buffer space |
| ev_tx_excoll | input | 1 | Transmit aborted after excessive collisions |
| ev_tx_underrun | input | 1 | Transmit FIFO underrun |
| ev_ring_ovw | input | 1 | Receive ring overwrite |
| ev_rdma_done | input | 1 | Remote DMA transfer complete |
| ev_pkt_removed | input | 1 | Host removed a frame from the ring |
| cmd_stop | input | 1 | Stop command issued |
| cmd_start | input | 1 | Start command issued |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_addr | input | 3 | Register address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, valid in the cycle of the read |
| irq | output | 1 | Interrupt request |

## Verification
Every status and counter update lands on the first rising edge that samples the stimulus. Read data is combinational and reflects that update from the following cycle onward, and `irq` changes in the same cycle as the status it depends on. The bench drives each stimulus on a falling edge and waits through one rising edge. It then samples results on the next falling edge, or one time unit after it for read data, so that each check falls exactly one edge after its cause. Coincident cases such as a set with a clear, or a read with an increment, are driven within a single cycle so that the priority rule decides the outcome.

// File: rtl/isr_pkg.sv
package isr_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam int NUM_CNT = 3;

  localparam logic [ADDR_W-1:0] A_STATUS = 3'd0;
  localparam logic [ADDR_W-1:0] A_MASK   = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT0   = 3'd2;

  localparam int B_RXOK  = 0;
  localparam int B_TXOK  = 1;
  localparam int B_RXERR = 2;
  localparam int B_TXERR = 3;
  localparam int B_OVW   = 4;
  localparam int B_CNTOV = 5;
  localparam int B_RDMA  = 6;
  localparam int B_STOP  = 7;
  localparam int NUM_EV  = 7;
endpackage

// File: rtl/tally_ctr.sv
module tally_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt,
  output logic             msb_rise
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = inc | clr;
    if (clr)
      cnt_d = inc ? CNT_W'(1) : '0;
    else if (inc && cnt_q != CNT_MAX)
      cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt      = cnt_q;
  assign msb_rise = ~cnt_q[CNT_W-1] & cnt_d[CNT_W-1];

  // R9
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !clr) |=> cnt_q == CNT_MAX);

  // R10
  rdclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !inc) |=> cnt_q == '0);
endmodule

// File: rtl/isr_status.sv
module isr_status
  import isr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EV-1:0] set_vec,
  input  logic              w1c_en,
  input  logic [NUM_EV-1:0] w1c_data,
  input  logic              stop_set,
  input  logic              stop_clr,
  output logic [DATA_W-1:0] stat
);
  logic [NUM_EV-1:0] ev_q, ev_d;
  logic              stp_q, stp_d;
  logic              ev_en, stp_en;

  always_comb begin
    ev_en  = w1c_en | (|set_vec);
    ev_d   = (ev_q & ~(w1c_en ? w1c_data : '0)) | set_vec;
    stp_en = stop_set | stop_clr;
    stp_d  = stop_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_q  <= '0;
      stp_q <= 1'b1;
    end else begin
      if (ev_en)  ev_q  <= ev_d;
      if (stp_en) stp_q <= stp_d;
    end
  end

  assign stat = {stp_q, ev_q};

  // R2
  evset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_vec[B_RXOK] |=> stat[B_RXOK]);

  // R5
  w1c_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (w1c_en && w1c_data == '0 && set_vec == '0) |=> $stable(stat[NUM_EV-1:0]));

  // R6
  rstbit_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_set && !stop_clr) |=> $stable(stat[B_STOP]));
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import isr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_rx_ok,
  input  logic              ev_tx_ok,
  input  logic              ev_rx_crc,
  input  logic              ev_rx_align,
  input  logic              ev_rx_fifo_ovr,
  input  logic              ev_rx_missed,
  input  logic              ev_tx_excoll,
  input  logic              ev_tx_underrun,
  input  logic              ev_ring_ovw,
  input  logic              ev_rdma_done,
  input  logic              ev_pkt_removed,
  input  logic              cmd_stop,
  input  logic              cmd_start,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              irq
);
  logic [NUM_CNT-1:0] cnt_inc, cnt_clr, cnt_msb;
  logic [CNT_W-1:0]   cnt_val [NUM_CNT];
  logic [NUM_EV-1:0]  set_vec;
  logic [DATA_W-1:0]  stat;
  logic [NUM_EV-1:0]  mask_q, mask_d;
  logic               mask_en;

  assign cnt_inc = {ev_rx_missed, ev_rx_crc, ev_rx_align};

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    assign cnt_clr[i] = host_rd && host_addr == A_CNT0 + ADDR_W'(i);
    tally_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .inc      (cnt_inc[i]),
      .clr      (cnt_clr[i]),
      .cnt      (cnt_val[i]),
      .msb_rise (cnt_msb[i])
    );
  end

  always_comb begin
    set_vec          = '0;
    set_vec[B_RXOK]  = ev_rx_ok;
    set_vec[B_TXOK]  = ev_tx_ok;
    set_vec[B_RXERR] = ev_rx_crc | ev_rx_align | ev_rx_fifo_ovr | ev_rx_missed;
    set_vec[B_TXERR] = ev_tx_excoll | ev_tx_underrun;
    set_vec[B_OVW]   = ev_ring_ovw;
    set_vec[B_CNTOV] = |cnt_msb;
    set_vec[B_RDMA]  = ev_rdma_done;
  end

  isr_status u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (set_vec),
    .w1c_en   (host_wr && host_addr == A_STATUS),
    .w1c_data (host_wdata[NUM_EV-1:0]),
    .stop_set (cmd_stop | ev_ring_ovw),
    .stop_clr (cmd_start | ev_pkt_removed),
    .stat     (stat)
  );

  always_comb begin
    mask_en = host_wr && host_addr == A_MASK;
    mask_d  = host_wdata[NUM_EV-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  always_comb begin
    host_rdata = '0;
    if (host_addr == A_STATUS)    host_rdata = stat;
    else if (host_addr == A_MASK) host_rdata = {1'b0, mask_q};
    else begin
      for (int k = 0; k < NUM_CNT; k++)
        if (host_addr == A_CNT0 + ADDR_W'(k)) host_rdata = DATA_W'(cnt_val[k]);
    end
  end

  assign irq = |(stat[NUM_EV-1:0] & mask_q);

  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[NUM_EV-1:0] == '0) |-> !irq);

  // R8
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);

  // R11
  cntov_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|cnt_msb) |=> stat[B_CNTOV]);
endmodule

// File: tb/sim_irq_status_unit.sv
`timescale 1ns/1ps
module sim_irq_status_unit;
  localparam int CLK_PERIOD = 10;
  localparam int E_RXOK = 0, E_TXOK = 1, E_CRC = 2, E_ALIGN = 3, E_FIFO = 4,
                 E_MISS = 5, E_XCOL = 6, E_UNDR = 7, E_OVW = 8, E_RDMA = 9,
                 E_REM = 10, E_STOP = 11, E_START = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [12:0] ev = '0;
  logic host_wr = 1'b0, host_rd = 1'b0;
  logic [2:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic irq;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_status_unit u0 (
    .clk(clk), .rst_n(rst_n),
    .ev_rx_ok(ev[E_RXOK]), .ev_tx_ok(ev[E_TXOK]), .ev_rx_crc(ev[E_CRC]),
    .ev_rx_align(ev[E_ALIGN]), .ev_rx_fifo_ovr(ev[E_FIFO]), .ev_rx_missed(ev[E_MISS]),
    .ev_tx_excoll(ev[E_XCOL]), .ev_tx_underrun(ev[E_UNDR]), .ev_ring_ovw(ev[E_OVW]),
    .ev_rdma_done(ev[E_RDMA]), .ev_pkt_removed(ev[E_REM]), .cmd_stop(ev[E_STOP]),
    .cmd_start(ev[E_START]), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  // drive a set of events for one cycle, with an optional status write in the same cycle
  task automatic fire(input logic [12:0] v, input bit wr_en = 1'b0, input logic [7:0] wd = '0);
    ev = v; host_wr = wr_en; host_addr = 3'd0; host_wdata = wd;
    step();
    ev = '0; host_wr = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    step();
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d, input logic [12:0] v = '0);
    host_rd = 1'b1; host_addr = a; ev = v;
    #1 d = host_rdata;
    step();
    host_rd = 1'b0; ev = '0;
  endtask

  task automatic expect_stat(input string req, input logic [7:0] exp);
    logic [7:0] d;
    rd(3'd0, d);
    chk(req, d, exp);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    expect_stat("R1 status", 8'h80);
    rd(3'd1, d); chk("R1 mask", d, 8'h00);
    for (int i = 2; i < 5; i++) begin rd(3'(i), d); chk("R1 counter", d, 8'h00); end
    chk("R1 irq", {7'd0, irq}, 8'h00);
    rd(3'd6, d); chk("R12 unused address", d, 8'h00);
  endtask

  task automatic t_stopbit();
    fire(13'(1) << E_START);            expect_stat("R6 start clears", 8'h00);
    wr(3'd0, 8'hFF);                    expect_stat("R6 write ignored", 8'h00);
    fire(13'(1) << E_STOP);             expect_stat("R6 stop sets", 8'h80);
    fire(13'(1) << E_START);
    fire(13'(1) << E_OVW);              expect_stat("R6 overwrite sets bit7 and bit4", 8'h90);
    fire(13'(1) << E_REM);              expect_stat("R6 removal clears", 8'h10);
    fire((13'(1) << E_STOP) | (13'(1) << E_START)); expect_stat("R6 set wins", 8'h90);
    fire(13'(1) << E_START);
    wr(3'd0, 8'h7F);                    expect_stat("R5 clear all", 8'h00);
  endtask

  task automatic t_events();
    fire(13'(1) << E_RXOK);  expect_stat("R2 rx ok", 8'h01);
    fire(13'(1) << E_TXOK);  expect_stat("R2 tx ok", 8'h03);
    fire(13'(1) << E_RDMA);  expect_stat("R2 rdma", 8'h43);
    wr(3'd0, 8'h00);         expect_stat("R5 zero write", 8'h43);
    wr(3'd0, 8'h02);         expect_stat("R5 partial clear", 8'h41);
    fire(13'(1) << E_RXOK, 1'b1, 8'h41); expect_stat("R5 set beats clear", 8'h01);
    wr(3'd0, 8'h7F);
    fire(13'(1) << E_FIFO);  expect_stat("R3 fifo overrun", 8'h04);
    wr(3'd0, 8'h04);
    fire(13'(1) << E_UNDR);  expect_stat("R4 underrun", 8'h08);
    wr(3'd0, 8'h08);
    fire(13'(1) << E_XCOL);  expect_stat("R4 excess collisions", 8'h08);
    wr(3'd0, 8'h7F);
  endtask

  task automatic t_mask_irq();
    logic [7:0] d;
    wr(3'd1, 8'hFF); rd(3'd1, d); chk("R7 mask bit7 reads 0", d, 8'h7F);
    fire(13'(1) << E_STOP);
    chk("R8 bit7 no irq", {7'd0, irq}, 8'h00);
    fire(13'(1) << E_START);
    wr(3'd1, 8'h01);
    fire(13'(1) << E_TXOK);
    chk("R8 masked bit no irq", {7'd0, irq}, 8'h00);
    fire(13'(1) << E_RXOK);
    chk("R8 unmasked raises irq", {7'd0, irq}, 8'h01);
    wr(3'd0, 8'h01);
    chk("R8 irq drops on clear", {7'd0, irq}, 8'h00);
    wr(3'd0, 8'h7F); wr(3'd1, 8'h00);
  endtask

  task automatic t_counters();
    logic [7:0] d;
    fire(13'(1) << E_CRC); fire(13'(1) << E_CRC); fire(13'(1) << E_CRC);
    expect_stat("R3 crc sets rx error", 8'h04);
    rd(3'd3, d); chk("R9 crc count", d, 8'd3);
    rd(3'd3, d); chk("R10 cleared by read", d, 8'd0);
    fire(13'(1) << E_MISS); fire(13'(1) << E_MISS);
    rd(3'd4, d); chk("R9 missed count", d, 8'd2);
    wr(3'd0, 8'h7F);
    for (int i = 0; i < 127; i++) fire(13'(1) << E_ALIGN);
    expect_stat("R11 no overflow at 127", 8'h04);
    fire(13'(1) << E_ALIGN);
    expect_stat("R11 overflow at 128", 8'h24);
    for (int i = 0; i < 172; i++) fire(13'(1) << E_ALIGN);
    rd(3'd2, d); chk("R9 saturates", d, 8'd255);
    rd(3'd2, d); chk("R10 read clears", d, 8'd0);
    fire(13'(1) << E_ALIGN);
    rd(3'd2, d, 13'(1) << E_ALIGN); chk("R10 read with increment", d, 8'd1);
    rd(3'd2, d); chk("R10 coincident increment kept", d, 8'd1);
    wr(3'd0, 8'h7F);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_stopbit();
    t_events();
    t_mask_irq();
    t_counters();
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule